// File: doc/BRIEF.md
# Reference Buffer Control and Trim Register Block

This block is the register front end for an on-chip voltage reference buffer. A simple register bus writes and reads two 32-bit registers. The mode register holds the buffer enable, the output-float select and the 3-bit level select, and it shows a ready flag. The trim register holds the 6-bit calibration code. The block drives the enable, float, level and trim values straight to the analog macro. It takes the macro's ready signal back through a synchronizer.

The trim code follows the level select by itself. On reset it loads the factory value for level 0 from a table supplied on input ports. Each time the level select takes a new value, it loads the factory value for that level. Once software writes the trim register, that automatic tracking stops until the next reset. The level select is locked while the buffer is enabled, so the reference level cannot shift under a running load.

Top module: `refbuf_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode register (offset 0x0) becomes all zeros. The trim register (offset 0x4) becomes the table entry for level 0, which is `trim_table[5:0]`. The override flag is cleared.
- R2: A write to offset 0x0 stores wdata bit 0 as the enable and wdata bit 1 as the float select (1 = output pin floating). Both appear on `ana_en_o` and `ana_hiz_o` after that clock edge and read back at bits 0 and 1.
- R3: The level select sits at bits 6:4 of offset 0x0. A write updates it only if the enable stored before that edge is 0. A write made while the buffer is enabled leaves it unchanged.
- R4: Bit 3 of offset 0x0 is read-only. It reads as `ana_ready_i` delayed through two clock stages, ANDed with the stored enable. Writes to bit 3 have no effect.
- R5: When the level select changes to a value from 0 to 3 and the override flag is clear, the trim register loads `trim_table[6*level +: 6]` at the same edge.
- R6: When the level select changes to a reserved value from 4 to 7, the trim register keeps its value.
- R7: A write to offset 0x4 stores wdata bits 5:0 in the trim register and sets the override flag. While the flag is set, level changes do not reload the trim. Only reset clears the flag.
- R8: Mode register bits 31:7 and bit 2 read as 0. Trim register bits 31:6 read as 0. Any other offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| trim_table | input | 24 | Factory trim codes, 6 bits per level, level 0 in the low bits |
| ana_ready_i | input | 1 | Ready signal from the analog macro, asynchronous |
| ana_en_o | output | 1 | Buffer enable |
| ana_hiz_o | output | 1 | Output pin float select |
| ana_scale_o | output | 3 | Level select |
| ana_trim_o | output | 6 | Trim code |

## Verification
The assertions assume that `trim_table` is steady around a level change, since the reload check compares the trim against the table after the edge. They also assume that only offsets 0x0, 0x4 and unmapped ones are accessed. The bench sets the table once before reset and never changes it. It drives the bus only on falling edges and holds `ana_ready_i` low, except in the directed ready test, where it changes only away from clock edges.

// File: rtl/refbuf_pkg.sv
package refbuf_pkg;
  localparam int DATA_W    = 32;
  localparam int MODE_OFS  = 0;
  localparam int TRIM_OFS  = 4;
  localparam int EN_POS    = 0;
  localparam int HIZ_POS   = 1;
  localparam int RDY_POS   = 3;
  localparam int LVL_POS   = 4;
  localparam int TRIM_POS  = 0;
endpackage

// File: rtl/refbuf_sync.sv
module refbuf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refbuf_mode.sv
module refbuf_mode #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             en_d,
  input  logic             hiz_d,
  input  logic [LVL_W-1:0] lvl_d,
  output logic             en_q,
  output logic             hiz_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             lvl_chg_o
);
  // the level is taken only if the enable stored before this edge is 0
  assign lvl_chg_o = wr_i && !en_q && (lvl_d != lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      hiz_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (wr_i) begin
        en_q  <= en_d;
        hiz_q <= hiz_d;
      end
      if (lvl_chg_o) lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/refbuf_trim.sv
module refbuf_trim #(
  parameter int TRIM_W = 6,
  parameter int LVL_W  = 3,
  parameter int NUM_LVL = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LVL*TRIM_W-1:0] table_i,
  input  logic                      lvl_chg_i,
  input  logic [LVL_W-1:0]          new_lvl_i,
  input  logic                      wr_i,
  input  logic [TRIM_W-1:0]         wdata_i,
  output logic [TRIM_W-1:0]         trim_q,
  output logic                      ovr_q,
  output logic                      reload_o
);
  function automatic logic [TRIM_W-1:0] pick_trim(
    input logic [NUM_LVL*TRIM_W-1:0] tbl,
    input logic [LVL_W-1:0]          lvl,
    input logic [TRIM_W-1:0]         keep);
    if (int'(lvl) < NUM_LVL) return tbl[int'(lvl)*TRIM_W +: TRIM_W];
    return keep;
  endfunction

  assign reload_o = lvl_chg_i && !ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trim_q <= table_i[TRIM_W-1:0];
      ovr_q  <= 1'b0;
    end else if (wr_i) begin
      trim_q <= wdata_i;
      ovr_q  <= 1'b1;
    end else if (reload_o) begin
      trim_q <= pick_trim(table_i, new_lvl_i, trim_q);
    end
  end
endmodule

// File: rtl/refbuf_ctrl.sv
module refbuf_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int TRIM_W  = 6,
  parameter int LVL_W   = 3,
  parameter int NUM_LVL = 4,
  parameter int SYNC_N  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_LVL*TRIM_W-1:0] trim_table,
  input  logic                      ana_ready_i,
  output logic                      ana_en_o,
  output logic                      ana_hiz_o,
  output logic [LVL_W-1:0]          ana_scale_o,
  output logic [TRIM_W-1:0]         ana_trim_o
);
  import refbuf_pkg::*;

  logic sel_mode, sel_trim, mode_wr, trim_wr;
  logic lvl_chg, trim_reload, ovr_q, rdy_sync, rdy_bit;

  assign sel_mode = (bus_addr == ADDR_W'(MODE_OFS));
  assign sel_trim = (bus_addr == ADDR_W'(TRIM_OFS));
  assign mode_wr  = bus_we && sel_mode;
  assign trim_wr  = bus_we && sel_trim;

  refbuf_mode #(.LVL_W(LVL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_i(mode_wr),
    .en_d(bus_wdata[EN_POS]), .hiz_d(bus_wdata[HIZ_POS]),
    .lvl_d(bus_wdata[LVL_POS +: LVL_W]),
    .en_q(ana_en_o), .hiz_q(ana_hiz_o), .lvl_q(ana_scale_o),
    .lvl_chg_o(lvl_chg)
  );

  refbuf_trim #(.TRIM_W(TRIM_W), .LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_trim (
    .clk(clk), .rst_n(rst_n), .table_i(trim_table),
    .lvl_chg_i(lvl_chg), .new_lvl_i(bus_wdata[LVL_POS +: LVL_W]),
    .wr_i(trim_wr), .wdata_i(bus_wdata[TRIM_POS +: TRIM_W]),
    .trim_q(ana_trim_o), .ovr_q(ovr_q), .reload_o(trim_reload)
  );

  refbuf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ana_ready_i), .q_o(rdy_sync)
  );

  assign rdy_bit = rdy_sync && ana_en_o;

  always_comb begin
    bus_rdata = '0;
    if (sel_mode) begin
      bus_rdata[EN_POS]             = ana_en_o;
      bus_rdata[HIZ_POS]            = ana_hiz_o;
      bus_rdata[RDY_POS]            = rdy_bit;
      bus_rdata[LVL_POS +: LVL_W]   = ana_scale_o;
    end else if (sel_trim) begin
      bus_rdata[TRIM_POS +: TRIM_W] = ana_trim_o;
    end
  end

  wire unused_wdata = ^{bus_wdata, trim_reload};
endmodule

// File: rtl/refbuf_chk.sv
module refbuf_chk #(
  parameter int ADDR_W  = 4,
  parameter int TRIM_W  = 6,
  parameter int LVL_W   = 3,
  parameter int NUM_LVL = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [NUM_LVL*TRIM_W-1:0] trim_table,
  input logic                      ana_en_o,
  input logic [LVL_W-1:0]          ana_scale_o,
  input logic [TRIM_W-1:0]         ana_trim_o,
  input logic                      lvl_chg,
  input logic                      trim_wr,
  input logic                      ovr_q,
  input logic                      rdy_bit
);
  logic [TRIM_W-1:0] exp_trim;
  logic              new_lvl_ok;
  always_comb begin
    exp_trim = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (int'(ana_scale_o) == i) exp_trim = trim_table[i*TRIM_W +: TRIM_W];
  end
  assign new_lvl_ok = int'(bus_wdata[6:4]) < NUM_LVL;

  assert_lvl_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_en_o && bus_we && bus_addr == '0) |=> $stable(ana_scale_o));

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en_o |-> !rdy_bit);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_chg && !ovr_q && new_lvl_ok) |=> (ana_trim_o == exp_trim));

  assert_reserved_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_chg && !new_lvl_ok) |=> $stable(ana_trim_o));

  assert_trim_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trim_wr |=> (ovr_q && ana_trim_o == $past(bus_wdata[TRIM_W-1:0])));

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  assert_ovr_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !trim_wr) |=> $stable(ana_trim_o));

  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata[31:7] == '0 && !bus_rdata[2]));
endmodule

bind refbuf_ctrl refbuf_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W), .LVL_W(LVL_W),
                             .NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trim_table(trim_table),
  .ana_en_o(ana_en_o), .ana_scale_o(ana_scale_o), .ana_trim_o(ana_trim_o),
  .lvl_chg(lvl_chg), .trim_wr(trim_wr), .ovr_q(ovr_q), .rdy_bit(rdy_bit)
);

// File: tb/test_refbuf_ctrl.sv
module test_refbuf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] T0 = 6'h11, T1 = 6'h22, T2 = 6'h2A, T3 = 6'h35;
  // entry: {we, waddr, wdata, raddr, expected read}
  localparam int NV = 15;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b1, 4'h0, 32'h0000_0020, 4'h0, 32'h0000_0020}, // R3 level 2 while off
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_002A}, // R5 reload level 2
    {1'b1, 4'h0, 32'h0000_0031, 4'h0, 32'h0000_0031}, // R3 level+enable same write
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_0035}, // R5 reload level 3
    {1'b1, 4'h0, 32'h0000_000B, 4'h0, 32'h0000_0033}, // R3 lock, R4 bit3 ignored
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_0035}, // R3 no reload when locked
    {1'b1, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_0030}, // R2 disable, level kept
    {1'b1, 4'h0, 32'hFFFF_FF50, 4'h0, 32'h0000_0050}, // R6 reserved 5, R8
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_0035}, // R6 trim kept
    {1'b1, 4'h0, 32'h0000_0010, 4'h0, 32'h0000_0010}, // R3 level 1
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_0022}, // R5 reload level 1
    {1'b1, 4'h4, 32'hFFFF_FF07, 4'h4, 32'h0000_0007}, // R7 write, R8 upper zero
    {1'b1, 4'h0, 32'h0000_0000, 4'h0, 32'h0000_0000}, // R7 level 0
    {1'b0, 4'h0, 32'h0,         4'h4, 32'h0000_0007}, // R7 override holds
    {1'b0, 4'h0, 32'h0,         4'h8, 32'h0000_0000}  // R8 unmapped
  };

  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, ana_ready_i = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [23:0] trim_table = {T3, T2, T1, T0};
  logic        ana_en_o, ana_hiz_o;
  logic [2:0]  ana_scale_o;
  logic [5:0]  ana_trim_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refbuf_ctrl i_refbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trim_table(trim_table),
    .ana_ready_i(ana_ready_i), .ana_en_o(ana_en_o), .ana_hiz_o(ana_hiz_o),
    .ana_scale_o(ana_scale_o), .ana_trim_o(ana_trim_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    rd_check("R1 mode reset", 4'h0, 32'h0);
    rd_check("R1 trim reset", 4'h4, {26'd0, T0});
    check("R1 outputs", {25'd0, ana_en_o, ana_hiz_o, ana_scale_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:68], VEC[i][67:36]);
      else @(negedge clk);
      rd_check($sformatf("vector %0d", i), VEC[i][35:32], VEC[i][31:0]);
    end

    // R2 outputs at the ports
    wr(4'h0, 32'h0000_0003);
    check("R2 en/hiz pins", {30'd0, ana_en_o, ana_hiz_o}, 32'h3);

    // R4 ready: two-stage delay, gated by enable (enable now 1)
    bus_addr = 4'h0;
    ana_ready_i = 1'b1;
    @(negedge clk); #1;
    check("R4 ready after 1 edge", {31'd0, bus_rdata[3]}, 32'h0);
    @(negedge clk); #1;
    check("R4 ready after 2 edges", {31'd0, bus_rdata[3]}, 32'h1);
    wr(4'h0, 32'h0000_0000);
    rd_check("R4 ready gated off", 4'h0, 32'h0);
    ana_ready_i = 1'b0;

    // R7 reset clears override, R5 reload resumes
    do_reset();
    rd_check("R7 trim after reset", 4'h4, {26'd0, T0});
    wr(4'h0, 32'h0000_0030);
    rd_check("R7 reload resumes", 4'h4, {26'd0, T3});
    check("R5 trim pin", {26'd0, ana_trim_o}, {26'd0, T3});

    done = 1;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin n_chk++; n_bad++; $display("FAIL watchdog: actual hung expected done"); end
  end

  initial begin
    wait (done || $time >= CLK_PERIOD * 5000);
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule